// File: doc/BRIEF.md
# Double-Rate Burst-of-Two SRAM with Split Data Ports

This block models a synchronous static RAM that has one data bus for writes and a separate data bus for reads. Both buses move data on the rising and the falling edge of a single input clock, and every transfer is a fixed burst of two beats. A read request and a write request may be issued in the same rising edge. In that case each one proceeds on its own address, without stalls.

On the write side, a deserializer collects the two beats of a burst into one double-width word. Each beat carries its own byte-lane enables. The word is merged lane by lane into an internal array in a single array write. Because the array word is twice the bus width, the address has one bit fewer than the beat-level depth. On the read side, one array access fetches a whole word. The output stage then sends the lower half and the upper half as two consecutive beats, with a valid flag beside them.

The read pipeline and the write pipeline are coherent. A read that is sampled together with, or after, a write to the same word returns the freshly merged data, even while that write is still waiting to reach the array.

Top module: `ddr_b2_sram`

## Requirements
- R1: A write sampled with `wr_req_i` high at a rising edge takes `wr_addr_i`, `d_i` and `be_i` at that edge as beat 0. It takes `d_i` and `be_i` at the next falling edge as beat 1. Beat 0 fills word bits [35:0] and beat 1 fills word bits [71:36].
- R2: Bit j of `be_i` (1 = write) enables lane j of the beat, which is `d_i` bits [9j+8:9j]. The enable is sampled with the same edge as its beat. Lanes whose enable is 0 keep their previous array contents.
- R3: A read sampled with `rd_req_i` high at rising edge T fetches the word at `rd_addr_i`. It drives word bits [35:0] on `q_o` while the clock is low between edges T+1 and T+2. It drives word bits [71:36] while the clock is high between edges T+2 and T+2.5 (1.5 cycles of latency to the first beat).
- R4: `q_valid_o` is high during exactly the two beat phases of each read named in R3, and low in every other phase.
- R5: A read and a write sampled at the same rising edge to different addresses both complete as if issued alone.
- R6: A read sampled at the same edge as a write to the same address, or at any later edge, returns the merged result of that write. A read sampled before a write returns the prior contents.
- R7: Reads issued on consecutive rising edges produce an unbroken stream of beats with `q_valid_o` held high.
- R8: While `rst_ni` is low, and after it is released with no read issued, `q_valid_o` is low.
- R9: A write burst whose enables are all zero in both beats leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; both edges transfer beats |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipelines |
| wr_req_i | input | 1 | Write burst request, sampled at rising edge |
| wr_addr_i | input | ADDR_W | Word address of the write |
| rd_req_i | input | 1 | Read burst request, sampled at rising edge |
| rd_addr_i | input | ADDR_W | Word address of the read |
| d_i | input | LANE_W*LANES | Write data beat (rising edge: beat 0, falling edge: beat 1) |
| be_i | input | LANES | Per-lane write enables for the current beat |
| q_o | output | LANE_W*LANES | Read data beat (low phase: beat 0, high phase: beat 1) |
| q_valid_o | output | 1 | High while `q_o` carries a read beat |

## Verification
The hardest situation to reach is a write and a read to the same word in the same rising edge while earlier traffic still occupies both pipelines. Only then does the fetched word have to come from the bypass, with partial lane enables mixed across the two beats. The stimulus first fills every word with full writes. It then applies directed cases: same-cycle write and read to one address, read-before-write ordering, all-zero and mixed enables, and back-to-back reads. After that it runs a long seeded random phase on a small array. In that phase, address collisions between simultaneous reads and writes with random enables happen often.

// File: rtl/ddr_b2_sram_pkg.sv
package ddr_b2_sram_pkg;
  localparam int unsigned LANE_W_DEF = 9;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 4;
endpackage

// File: rtl/ddr_b2_wr_deser.sv
module ddr_b2_wr_deser #(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned BEAT_W = LANE_W * LANES,
  localparam int unsigned WORD_W = 2 * BEAT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_req_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [BEAT_W-1:0]    d_i,
  input  logic [LANES-1:0]     be_i,
  output logic                 commit_en_o,
  output logic [ADDR_W-1:0]    commit_addr_o,
  output logic [WORD_W-1:0]    commit_data_o,
  output logic [2*LANES-1:0]   commit_mask_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] d0_q, d1_q;
  logic [LANES-1:0]  be0_q, be1_q;

  // beat 0 with the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      d0_q   <= '0;
      be0_q  <= '0;
    end else begin
      pend_q <= wr_req_i;
      if (wr_req_i) begin
        addr_q <= wr_addr_i;
        d0_q   <= d_i;
        be0_q  <= be_i;
      end
    end
  end

  // beat 1 on the following falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q  <= '0;
      be1_q <= '0;
    end else if (pend_q) begin
      d1_q  <= d_i;
      be1_q <= be_i;
    end
  end

  assign commit_en_o   = pend_q;
  assign commit_addr_o = addr_q;
  assign commit_data_o = {d1_q, d0_q};
  assign commit_mask_o = {be1_q, be0_q};
endmodule

// File: rtl/ddr_b2_array.sv
module ddr_b2_array #(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned NLANES = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WORD_W = LANE_W * NLANES,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NLANES-1:0] wmask_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              hit;

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < int'(NLANES); l++) begin
      if (we_i && wmask_i[l])
        mem_q[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  // bypass keeps a read coherent with a write committing in the same edge
  assign hit = we_i && (waddr_i == raddr_i);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign rdata_o[g*LANE_W +: LANE_W] = (hit && wmask_i[g]) ?
        wdata_i[g*LANE_W +: LANE_W] : mem_q[raddr_i][g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ddr_b2_rd_ser.sv
module ddr_b2_rd_ser #(
  parameter int unsigned BEAT_W = 36,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WORD_W = 2 * BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] fetch_data_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_valid_o,
  output logic              lo_valid_o,
  output logic [BEAT_W-1:0] q_o,
  output logic              q_valid_o
);
  logic              s1_v, s2_v, vneg_q, vpos_q;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] word_q;
  logic [BEAT_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s2_v    <= 1'b0;
      word_q  <= '0;
      hi_q    <= '0;
      vpos_q  <= 1'b0;
    end else begin
      s1_v <= rd_req_i;
      if (rd_req_i) s1_addr <= rd_addr_i;
      s2_v <= s1_v;
      if (s1_v) word_q <= fetch_data_i;
      hi_q   <= word_q[WORD_W-1:BEAT_W];
      vpos_q <= s2_v;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      vneg_q <= 1'b0;
    end else begin
      lo_q   <= word_q[BEAT_W-1:0];
      vneg_q <= s2_v;
    end
  end

  // output clocks tied off: beats launched from the input clock phases
  assign q_o           = clk_i ? hi_q : lo_q;
  assign q_valid_o     = clk_i ? vpos_q : vneg_q;
  assign fetch_addr_o  = s1_addr;
  assign fetch_valid_o = s1_v;
  assign lo_valid_o    = vneg_q;
endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
  import ddr_b2_sram_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned BEAT_W = LANE_W * LANES,
  localparam int unsigned WORD_W = 2 * BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [BEAT_W-1:0] d_i,
  input  logic [LANES-1:0]  be_i,
  output logic [BEAT_W-1:0] q_o,
  output logic              q_valid_o
);
  logic                commit_en;
  logic [ADDR_W-1:0]   commit_addr;
  logic [WORD_W-1:0]   commit_data;
  logic [2*LANES-1:0]  commit_mask;
  logic [ADDR_W-1:0]   fetch_addr;
  logic [WORD_W-1:0]   fetch_data;
  logic                fetch_valid;
  logic                lo_valid;

  ddr_b2_wr_deser #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni, .wr_req_i, .wr_addr_i, .d_i, .be_i,
    .commit_en_o(commit_en), .commit_addr_o(commit_addr),
    .commit_data_o(commit_data), .commit_mask_o(commit_mask)
  );

  ddr_b2_array #(.LANE_W(LANE_W), .NLANES(2*LANES), .ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(commit_en), .waddr_i(commit_addr), .wdata_i(commit_data),
    .wmask_i(commit_mask), .raddr_i(fetch_addr), .rdata_o(fetch_data)
  );

  ddr_b2_rd_ser #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .rd_req_i, .rd_addr_i, .fetch_data_i(fetch_data),
    .fetch_addr_o(fetch_addr), .fetch_valid_o(fetch_valid),
    .lo_valid_o(lo_valid), .q_o, .q_valid_o
  );
endmodule

// File: rtl/ddr_b2_sram_chk.sv
module ddr_b2_sram_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_req_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic               rd_req_i,
  input logic [LANES-1:0]   be_i,
  input logic               commit_en,
  input logic [ADDR_W-1:0]  commit_addr,
  input logic [2*LANES-1:0] commit_mask,
  input logic               fetch_valid,
  input logic               lo_valid
);
  a_r1_commit_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en == $past(wr_req_i));

  a_r1_commit_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |-> commit_addr == $past(wr_addr_i));

  a_r2_beat0_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |-> commit_mask[LANES-1:0] == $past(be_i));

  a_r3_fetch_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid == $past(rd_req_i));

  a_r4_low_phase_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid == $past(rd_req_i, 2));
endmodule

bind ddr_b2_sram ddr_b2_sram_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_req_i(wr_req_i), .wr_addr_i(wr_addr_i),
  .rd_req_i(rd_req_i), .be_i(be_i), .commit_en(commit_en),
  .commit_addr(commit_addr), .commit_mask(commit_mask),
  .fetch_valid(fetch_valid), .lo_valid(lo_valid)
);

// File: tb/ddr_b2_sram_bench.sv
module ddr_b2_sram_bench;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int AW = 4;
  localparam int BW = LW * NL;
  localparam int WW = 2 * BW;
  localparam int DEPTH = 1 << AW;
  localparam int NOPS = 600;

  logic          clk, rst_n;
  logic          wr_req, rd_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [BW-1:0] d, q;
  logic [NL-1:0] be;
  logic          q_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          op_wr [NOPS];
  logic          op_rd [NOPS];
  logic [AW-1:0] op_wa [NOPS];
  logic [AW-1:0] op_ra [NOPS];
  logic [BW-1:0] op_d0 [NOPS];
  logic [BW-1:0] op_d1 [NOPS];
  logic [NL-1:0] op_b0 [NOPS];
  logic [NL-1:0] op_b1 [NOPS];
  logic [WW-1:0] op_exp [NOPS];
  string         op_tag [NOPS];
  logic [WW-1:0] model [DEPTH];

  ddr_b2_sram #(.LANE_W(LW), .LANES(NL), .ADDR_W(AW)) u_ddr_b2_sram (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_addr_i(wr_addr),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .d_i(d), .be_i(be),
    .q_o(q), .q_valid_o(q_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw,
                                          logic [2*NL-1:0] m);
    logic [WW-1:0] r = old;
    for (int l = 0; l < 2*NL; l++)
      if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [BW-1:0] rnd_beat();
    return BW'({$urandom, $urandom});
  endfunction

  task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_op(int k, logic w, logic [AW-1:0] wa, logic [NL-1:0] b0,
                        logic [NL-1:0] b1, logic r, logic [AW-1:0] ra, string tag);
    op_wr[k] = w; op_wa[k] = wa; op_b0[k] = b0; op_b1[k] = b1;
    op_rd[k] = r; op_ra[k] = ra; op_tag[k] = tag;
    op_d0[k] = rnd_beat(); op_d1[k] = rnd_beat();
  endtask

  task automatic drive_ctrl(int k);
    if (k < NOPS) begin
      wr_req = op_wr[k]; wr_addr = op_wa[k]; rd_req = op_rd[k]; rd_addr = op_ra[k];
      d = op_d0[k]; be = op_b0[k];
    end else begin
      wr_req = 0; rd_req = 0; wr_addr = '0; rd_addr = '0; d = '0; be = '0;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // preload every word (R1), then directed cases, then random
    for (int k = 0; k < DEPTH; k++) set_op(k, 1, AW'(k), '1, '1, 0, '0, "R1");
    set_op(16, 0, '0, '0, '0, 1, 4'd3, "R1");
    set_op(17, 1, 4'd5, 4'b0101, 4'b1000, 0, '0, "R2");
    set_op(18, 0, '0, '0, '0, 1, 4'd5, "R2");
    set_op(19, 1, 4'd6, 4'b0000, 4'b0000, 0, '0, "R9");
    set_op(20, 0, '0, '0, '0, 1, 4'd6, "R9");
    set_op(21, 1, 4'd7, 4'b1111, 4'b0110, 1, 4'd7, "R6");
    set_op(22, 1, 4'd8, 4'b1111, 4'b1111, 1, 4'd9, "R5");
    for (int k = 23; k < 28; k++) set_op(k, 0, '0, '0, '0, 1, AW'(k), "R7");
    set_op(28, 0, '0, '0, '0, 1, 4'd2, "R6");
    set_op(29, 1, 4'd2, 4'b1111, 4'b1111, 0, '0, "R6");
    set_op(30, 0, '0, '0, '0, 1, 4'd2, "R6");
    for (int k = 31; k < NOPS; k++) begin
      logic w = 1'($urandom);
      logic r = 1'($urandom);
      logic [NL-1:0] b0 = ($urandom % 3 == 0) ? NL'($urandom) : '1;
      logic [NL-1:0] b1 = ($urandom % 3 == 0) ? NL'($urandom) : '1;
      set_op(k, w, AW'($urandom), b0, b1, r, AW'($urandom), (w && r) ? "R5" : "R3");
      if (w && r && ($urandom % 2 == 0)) begin
        op_ra[k] = op_wa[k];
        op_tag[k] = "R6";
      end
    end
    for (int k = 0; k < NOPS; k++) begin
      if (op_wr[k])
        model[op_wa[k]] = merge(model[op_wa[k]], {op_d1[k], op_d0[k]}, {op_b1[k], op_b0[k]});
      op_exp[k] = op_rd[k] ? model[op_ra[k]] : '0;
    end

    rst_n = 0; drive_ctrl(NOPS);
    repeat (3) @(posedge clk);
    #2;
    chk("R8", BW'(q_valid), '0);
    @(negedge clk); #2;
    rst_n = 1;
    @(posedge clk); #2;
    chk("R8", BW'(q_valid), '0);
    @(negedge clk); #2;
    chk("R8", BW'(q_valid), '0);
    drive_ctrl(0);

    for (int k = 0; k < NOPS + 3; k++) begin
      @(posedge clk); #2;
      if (k < NOPS) begin d = op_d1[k]; be = op_b1[k]; end
      if (k >= 2) begin
        if (k - 2 < NOPS && op_rd[k-2]) begin
          chk("R4", BW'(q_valid), BW'(1));
          chk(op_tag[k-2] == "R1" ? "R1" : op_tag[k-2], q, op_exp[k-2][WW-1:BW]);
        end else chk("R4", BW'(q_valid), '0);
      end
      @(negedge clk); #2;
      if (k >= 1) begin
        if (k - 1 < NOPS && op_rd[k-1]) begin
          chk("R4", BW'(q_valid), BW'(1));
          chk(op_tag[k-1] == "R7" ? "R7" : op_tag[k-1], q, op_exp[k-1][BW-1:0]);
        end else chk("R4", BW'(q_valid), '0);
      end
      drive_ctrl(k + 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule